// File: doc/BRIEF.md
# HDLC Opening-Flag Detector with Carrier Gating

The block watches a serial bit stream taken from a low-speed receive channel and looks for the HDLC flag octet `01111110` (0x7E). Each incoming bit is qualified by a strobe. A run of flags is counted only when each flag follows the one before it at octet spacing. Flags that share a zero bit with the previous flag are also accepted. When the third flag of such a run completes, the block raises a flag-seen indication. This indication is bit 6 of an 8-bit status byte (bit 7 is the MSB). The indication falls again once a full octet of valid bits passes without a new flag.

Detection is meant to run while a receiver waits for either a low-speed control message or a high-speed training sequence. A host-controlled enable switches the detector on and off. A high-speed carrier-detect input switches it off automatically while that carrier is present. Either kind of disable wipes all progress. After a disable, the detector needs three fresh flags once it is re-enabled, for example after the high-speed carrier is lost.

Top module: `hdlc_flag_det`

## Requirements
- R1: After reset, and in every cycle, `status_o` bits other than bit 6 read 0. Right after reset the whole byte is 0x00.
- R2: The bit input is sampled only in cycles where `bit_vld_i` is 1. Changes on `bit_i` while the strobe is low do not affect the count or the status.
- R3: Status bit 6 becomes 1 in the cycle after the valid bit that completes the third flag of a run. In a run, each flag ends exactly 8 valid bits after the previous flag, so with back-to-back flags the indication appears after the 24th bit and not after the 23rd.
- R4: A flag that ends 7 valid bits after the previous one (its leading 0 is the previous flag's trailing 0) also continues the run. Three such flags raise the indication after 22 bits.
- R5: If 8 valid bits pass after a flag with no new flag, the run count drops to zero. The next flag then starts a new run at count one.
- R6: While the indication is set, each further aligned flag keeps it set. It stays set through 7 valid bits with no flag. It clears in the cycle after the 8th such bit.
- R7: While `carrier_i` is 1, the detector is disabled. The status reads 0x00 from the cycle after the first clock edge with the carrier high, and flags received while the carrier is high are not counted.
- R8: While `det_en_i` is 0, the detector is disabled in the same way as under R7.
- R9: After a disable (R7 or R8) ends, the indication needs three new flags. Flags seen before the disable do not count.
- R10: If a disable arrives in the same cycle as the bit that would complete the third flag, the disable wins and the status stays 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Received serial data bit |
| bit_vld_i | input | 1 | Strobe, high for one cycle per new bit |
| carrier_i | input | 1 | High-speed carrier detect; disables detection while high |
| det_en_i | input | 1 | Host enable for detection |
| status_o | output | 8 | Status byte; bit 6 is the flag-seen indication |

## Verification
Two functions can act on the same clock edge: the bit that completes the third flag, and a disable from the carrier input or the host enable. The bench drives the final bit of the third flag in the same cycle that `carrier_i` rises. It expects the status to stay 0x00. It then checks that only a full new run of three flags restores the indication. The same edge-sharing idea is applied to the hold window by checking the 7th and 8th flag-free bits one by one.

// File: rtl/hdlc_fdet_pkg.sv
package hdlc_fdet_pkg;
  localparam int unsigned FLAG_W   = 8;
  localparam logic [7:0]  FLAG_OCT = 8'h7E;
  localparam int unsigned RUN_NEED = 3;
endpackage

// File: rtl/fdet_gate.sv
module fdet_gate (
  input  logic det_en_i,
  input  logic carrier_i,
  output logic active_o
);
  // carrier presence overrides the host enable
  assign active_o = det_en_i & ~carrier_i;
endmodule

// File: rtl/fdet_shift.sv
module fdet_shift #(
  parameter int unsigned W   = 8,
  parameter logic [W-1:0] PAT = 8'h7E
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         vld_i,
  input  logic         bit_i,
  output logic         match_o,
  output logic [W-1:0] sr_o
);
  logic [W-1:0] sr_q;
  logic [W-1:0] win;

  assign win     = {sr_q[W-2:0], bit_i};
  assign match_o = vld_i & (win == PAT);
  assign sr_o    = sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sr_q <= '0;
    else if (clr_i) sr_q <= '0;
    else if (vld_i) sr_q <= win;
  end
endmodule

// File: rtl/fdet_run.sv
module fdet_run #(
  parameter int unsigned NEED        = 3,
  parameter int unsigned HOLD        = 8,
  parameter bit          SHARED_ZERO = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic vld_i,
  input  logic match_i,
  output logic det_o
);
  localparam int unsigned CW = $clog2(NEED + 1);
  localparam int unsigned DW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt_q, cnt_inc;
  logic [DW-1:0] dist_q, dist_n;
  logic          det_q;
  logic          aligned;

  assign cnt_inc = (cnt_q == CW'(NEED)) ? cnt_q : cnt_q + 1'b1;
  assign dist_n  = (dist_q == DW'(HOLD)) ? dist_q : dist_q + 1'b1;

  generate
    if (SHARED_ZERO) begin : g_shared
      assign aligned = (dist_n == DW'(HOLD)) || (dist_n == DW'(HOLD - 1));
    end else begin : g_strict
      assign aligned = (dist_n == DW'(HOLD));
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      dist_q <= '0;
      det_q  <= 1'b0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      dist_q <= '0;
      det_q  <= 1'b0;
    end else if (vld_i) begin
      if (match_i) begin
        dist_q <= '0;
        if (cnt_q == '0) begin
          cnt_q <= CW'(1);
          det_q <= (NEED == 1);
        end else if (aligned) begin
          cnt_q <= cnt_inc;
          if (cnt_inc == CW'(NEED)) det_q <= 1'b1;
        end else begin
          // misplaced flag restarts the run
          cnt_q <= CW'(1);
          det_q <= 1'b0;
        end
      end else if (dist_n == DW'(HOLD)) begin
        cnt_q  <= '0;
        dist_q <= dist_n;
        det_q  <= 1'b0;
      end else begin
        dist_q <= dist_n;
      end
    end
  end

  assign det_o = det_q;
endmodule

// File: rtl/hdlc_flag_det.sv
module hdlc_flag_det
  import hdlc_fdet_pkg::*;
#(
  parameter int unsigned       OCT_W       = FLAG_W,
  parameter logic [OCT_W-1:0]  FLAG_PAT    = FLAG_OCT,
  parameter int unsigned       NEED        = RUN_NEED,
  parameter int unsigned       STATUS_W    = 8,
  parameter int unsigned       STATUS_BIT  = 6,
  parameter bit                SHARED_ZERO = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_i,
  input  logic                bit_vld_i,
  input  logic                carrier_i,
  input  logic                det_en_i,
  output logic [STATUS_W-1:0] status_o
);
  localparam int unsigned HOLD = OCT_W;

  logic             active;
  logic             match;
  logic             det;
  logic [OCT_W-1:0] sr_q;

  fdet_gate u_gate (
    .det_en_i (det_en_i),
    .carrier_i(carrier_i),
    .active_o (active)
  );

  fdet_shift #(.W(OCT_W), .PAT(FLAG_PAT)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (~active),
    .vld_i  (bit_vld_i),
    .bit_i  (bit_i),
    .match_o(match),
    .sr_o   (sr_q)
  );

  fdet_run #(.NEED(NEED), .HOLD(HOLD), .SHARED_ZERO(SHARED_ZERO)) u_run (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (~active),
    .vld_i  (bit_vld_i),
    .match_i(match),
    .det_o  (det)
  );

  for (genvar i = 0; i < STATUS_W; i++) begin : g_stat
    if (i == STATUS_BIT) begin : g_flag
      assign status_o[i] = det;
    end else begin : g_zero
      assign status_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/hdlc_flag_det_chk.sv
module hdlc_flag_det_chk #(
  parameter int unsigned      OCT_W      = 8,
  parameter logic [OCT_W-1:0] FLAG_PAT   = 8'h7E,
  parameter int unsigned      STATUS_W   = 8,
  parameter int unsigned      STATUS_BIT = 6
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                bit_i,
  input logic                bit_vld_i,
  input logic                carrier_i,
  input logic                det_en_i,
  input logic [STATUS_W-1:0] status_o,
  input logic [OCT_W-1:0]    sr_q
);
  p_rise_on_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[STATUS_BIT]) |-> $past(bit_vld_i && ({sr_q[OCT_W-2:0], bit_i} == FLAG_PAT)));

  p_carrier_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carrier_i |=> !status_o[STATUS_BIT]);

  p_enable_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !det_en_i |=> !status_o[STATUS_BIT]);

  p_no_strobe_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_vld_i && det_en_i && !carrier_i) |=> $stable(status_o));

  p_rise_needs_active_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[STATUS_BIT]) |-> $past(det_en_i && !carrier_i));
endmodule

bind hdlc_flag_det hdlc_flag_det_chk #(
  .OCT_W(OCT_W), .FLAG_PAT(FLAG_PAT), .STATUS_W(STATUS_W), .STATUS_BIT(STATUS_BIT)
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .bit_i    (bit_i),
  .bit_vld_i(bit_vld_i),
  .carrier_i(carrier_i),
  .det_en_i (det_en_i),
  .status_o (status_o),
  .sr_q     (sr_q)
);

// File: tb/hdlc_flag_det_tb_top.sv
module hdlc_flag_det_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [7:0] SET = 8'h40;
  localparam logic [7:0] CLR = 8'h00;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       bit_i = 1'b0;
  logic       bit_vld_i = 1'b0;
  logic       carrier_i = 1'b0;
  logic       det_en_i = 1'b1;
  logic [7:0] status_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  hdlc_flag_det dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(bit_i), .bit_vld_i(bit_vld_i),
    .carrier_i(carrier_i), .det_en_i(det_en_i), .status_o(status_o)
  );

  task automatic check(input string req, input logic [7:0] exp);
    n_chk++;
    if (status_o !== exp) begin
      n_fail++;
      $display("FAIL %s: status actual %02h expected %02h", req, status_o, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; bit_vld_i = 1'b0; bit_i = 1'b0; carrier_i = 1'b0; det_en_i = 1'b1;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // one bit: strobe high one cycle, low the next; status sampled on return
  task automatic send_bit(input logic b);
    @(negedge clk_i);
    bit_i = b; bit_vld_i = 1'b1;
    @(negedge clk_i);
    bit_vld_i = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic send_flag();
    send_byte(8'h7E);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 reset value", CLR);
  endtask

  task automatic t_aligned();
    do_reset();
    send_flag(); send_flag();
    check("R3 two flags only", CLR);
    for (int i = 0; i < 7; i++) send_bit(i != 0);
    check("R3 after 23 bits", CLR);
    send_bit(1'b0);
    check("R3 after 24 bits", SET);
  endtask

  task automatic t_shared();
    do_reset();
    send_bit(1'b0);
    for (int f = 0; f < 3; f++) begin
      for (int i = 0; i < 6; i++) send_bit(1'b1);
      if (f == 2) check("R4 after 21 bits", CLR);
      send_bit(1'b0);
    end
    check("R4 shared-zero run", SET);
  endtask

  task automatic t_break();
    do_reset();
    send_flag(); send_flag();
    send_byte(8'h00);
    send_flag(); send_flag();
    check("R5 run broken by idle octet", CLR);
    send_flag();
    check("R5 new run completes", SET);
  endtask

  task automatic t_hold();
    do_reset();
    repeat (3) send_flag();
    repeat (2) send_flag();
    check("R6 held by further flags", SET);
    for (int i = 0; i < 7; i++) send_bit(1'b1);
    check("R6 held through 7 bits", SET);
    send_bit(1'b1);
    check("R6 cleared after 8 bits", CLR);
    check("R1 other bits zero", status_o & 8'hBF);
  endtask

  task automatic t_strobe();
    do_reset();
    send_flag(); send_flag();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      bit_i = i[0];
    end
    check("R2 no change while strobe low", CLR);
    send_flag();
    check("R2 ignored bits did not break run", SET);
  endtask

  task automatic t_carrier();
    do_reset();
    repeat (3) send_flag();
    check("R7 set before carrier", SET);
    @(negedge clk_i); carrier_i = 1'b1;
    @(negedge clk_i);
    check("R7 cleared by carrier", CLR);
    repeat (3) send_flag();
    check("R7 no count under carrier", CLR);
    @(negedge clk_i); carrier_i = 1'b0;
    send_flag(); send_flag();
    check("R9 two fresh flags after carrier", CLR);
    send_flag();
    check("R9 three fresh flags after carrier", SET);
  endtask

  task automatic t_enable();
    do_reset();
    send_flag(); send_flag();
    @(negedge clk_i); det_en_i = 1'b0;
    send_flag();
    check("R8 no detection while disabled", CLR);
    @(negedge clk_i); det_en_i = 1'b1;
    send_flag();
    check("R9 pre-disable flags forgotten", CLR);
    send_flag(); send_flag();
    check("R8 detection after re-enable", SET);
    @(negedge clk_i); det_en_i = 1'b0;
    @(negedge clk_i);
    check("R8 cleared by enable low", CLR);
    det_en_i = 1'b1;
  endtask

  task automatic t_collide();
    do_reset();
    send_flag(); send_flag();
    for (int i = 0; i < 7; i++) send_bit(i != 0);
    @(negedge clk_i);
    bit_i = 1'b0; bit_vld_i = 1'b1; carrier_i = 1'b1;
    @(negedge clk_i);
    bit_vld_i = 1'b0;
    check("R10 disable wins over third flag", CLR);
    carrier_i = 1'b0;
    send_flag(); send_flag();
    check("R10 run restarted", CLR);
    send_flag();
    check("R10 fresh run sets", SET);
  endtask

  initial begin
    t_reset();
    t_aligned();
    t_shared();
    t_break();
    t_hold();
    t_strobe();
    t_carrier();
    t_enable();
    t_collide();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule